// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This unit settles which NaN a two-input floating-point operation returns once the caller has found that at least one of its two same-format operands is a NaN. It sorts each operand as signaling NaN, quiet NaN or non-NaN, and picks one operand under a static priority policy. It then outputs that operand with its quiet bit forced on, or the format's default NaN when default-NaN mode is set. Alongside the result it reports an invalid-operation flag.

The selection logic is purely combinational. One registered stage with a valid/ready handshake on each side holds the result and the flag. The operand width is a parameter, with 32-bit and 64-bit formats supported. The exponent field is 8 bits wide for 32-bit operands and 11 bits wide for 64-bit operands. The quiet bit is the most significant mantissa bit. Operands in which neither value is a NaN lie outside the unit's contract.

Top module: `nan_pick_unit`

## Requirements
- R1: While reset is held and directly after it is released, `out_valid_o` is 0.
- R2: `invalid_o` is 1 exactly when at least one accepted operand is a signaling NaN (exponent all ones, quiet bit 0, mantissa nonzero). This holds in default-NaN mode too.
- R3: With `dflt_nan_i` = 1 the result is the default NaN for every policy: sign 0, exponent all ones, only the quiet bit set in the mantissa (32'h7FC00000 for 32-bit operands).
- R4: With policy 0, the first match in this list wins: A if signaling, then B if signaling, then A if quiet, otherwise B.
- R5: With policy 1, A wins if it is any NaN; otherwise B wins.
- R6: With policy 2 and operands of different kinds, a quiet NaN beats a signaling NaN, and any NaN beats a non-NaN.
- R7: With policy 2 and both operands the same kind of NaN, the operand with the larger magnitude wins. Magnitude is the encoding with the sign bit removed, compared as an unsigned number.
- R8: With policy 2, same-kind NaNs and equal magnitudes, A wins only when its raw encoding is numerically below B's (A positive, B negative); otherwise B wins.
- R9: The selected operand leaves with its quiet bit set and all other bits unchanged, so the unit never outputs a signaling NaN.
- R10: `in_ready_o` is 1 when the output stage is empty or `out_ready_i` is 1. A result is captured only on an input handshake. It holds stable while `out_valid_o` = 1 and `out_ready_i` = 0.
- R11: Policy code 3 selects exactly as policy 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair is valid |
| in_ready_o | output | 1 | Unit accepts an operand pair |
| opa_i | input | FLEN | Operand A |
| opb_i | input | FLEN | Operand B |
| policy_i | input | 2 | Selection policy: 0 ordered, 1 A-first, 2 magnitude, 3 as 0 |
| dflt_nan_i | input | 1 | Default-NaN mode |
| out_valid_o | output | 1 | Result is valid |
| out_ready_i | input | 1 | Consumer accepts the result |
| result_o | output | FLEN | Selected, quieted NaN or default NaN |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The bench builds the unit with FLEN = 32. At that width the exponent, quiet-bit and sign positions are short enough to write signaling, quiet and tie-magnitude operands by hand. The random phase draws mantissas from a tiny set, so equal magnitudes with opposite signs occur often and exercise the sign tie-break. FLEN = 64 uses the same generate path, with only the derived field widths changed.

// File: rtl/nan_pick_pkg.sv
package nan_pick_pkg;

  typedef enum logic [1:0] {
    POL_ORDERED   = 2'd0,
    POL_FIRST_NAN = 2'd1,
    POL_MAGNITUDE = 2'd2,
    POL_ALIAS     = 2'd3
  } nan_policy_e;

  function automatic int exp_bits(input int flen);
    if (flen == 64) return 11;
    return 8;
  endfunction

endpackage

// File: rtl/nan_classify.sv
module nan_classify #(
  parameter int FLEN = 32
) (
  input  logic [FLEN-1:0] op_i,
  output logic            is_snan_o,
  output logic            is_qnan_o
);
  import nan_pick_pkg::*;

  localparam int EXP_W = exp_bits(FLEN);
  localparam int MAN_W = FLEN - 1 - EXP_W;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;

  assign exp_f   = op_i[FLEN-2 -: EXP_W];
  assign man_f   = op_i[MAN_W-1:0];
  assign exp_max = &exp_f;

  assign is_qnan_o = exp_max & man_f[MAN_W-1];
  assign is_snan_o = exp_max & ~man_f[MAN_W-1] & (|man_f[MAN_W-2:0]);

endmodule

// File: rtl/nan_arbiter.sv
module nan_arbiter #(
  parameter int FLEN = 32
) (
  input  logic [FLEN-1:0] opa_i,
  input  logic [FLEN-1:0] opb_i,
  input  logic            a_snan_i,
  input  logic            a_qnan_i,
  input  logic            b_snan_i,
  input  logic            b_qnan_i,
  input  logic [1:0]      policy_i,
  output logic            pick_b_o
);
  import nan_pick_pkg::*;

  logic [FLEN-2:0] mag_a, mag_b;
  logic            a_larger;

  assign mag_a = opa_i[FLEN-2:0];
  assign mag_b = opb_i[FLEN-2:0];

  // equal magnitude: raw-encoding order makes positive A win over negative B
  assign a_larger = (mag_a > mag_b) | ((mag_a == mag_b) & (opa_i < opb_i));

  always_comb begin
    unique case (nan_policy_e'(policy_i))
      POL_FIRST_NAN: pick_b_o = ~(a_snan_i | a_qnan_i);
      POL_MAGNITUDE: begin
        if (a_snan_i)      pick_b_o = b_snan_i ? ~a_larger : b_qnan_i;
        else if (a_qnan_i) pick_b_o = b_qnan_i & ~a_larger;
        else               pick_b_o = 1'b1;
      end
      default:       pick_b_o = ~a_snan_i & (b_snan_i | ~a_qnan_i);
    endcase
  end

endmodule

// File: rtl/nan_result_fmt.sv
module nan_result_fmt #(
  parameter int FLEN = 32
) (
  input  logic [FLEN-1:0] pick_i,
  input  logic            pick_snan_i,
  input  logic            dflt_nan_i,
  output logic [FLEN-1:0] res_o
);
  import nan_pick_pkg::*;

  localparam int EXP_W = exp_bits(FLEN);
  localparam int MAN_W = FLEN - 1 - EXP_W;
  localparam logic [FLEN-1:0] QBIT     = FLEN'(1) << (MAN_W - 1);
  localparam logic [FLEN-1:0] DFLT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  always_comb begin
    if (dflt_nan_i)       res_o = DFLT_NAN;
    else if (pick_snan_i) res_o = pick_i | QBIT;
    else                  res_o = pick_i;
  end

endmodule

// File: rtl/nan_pick_unit.sv
module nan_pick_unit #(
  parameter int FLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [FLEN-1:0] opa_i,
  input  logic [FLEN-1:0] opb_i,
  input  logic [1:0]      policy_i,
  input  logic            dflt_nan_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [FLEN-1:0] result_o,
  output logic            invalid_o
);
  import nan_pick_pkg::*;

  localparam int EXP_W  = exp_bits(FLEN);
  localparam int MAN_W  = FLEN - 1 - EXP_W;
  localparam int N_OPS  = 2;
  localparam logic [FLEN-1:0] DFLT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [FLEN-1:0] ops [N_OPS];
  logic [N_OPS-1:0] snan_v, qnan_v;
  logic            pick_b;
  logic [FLEN-1:0] pick_op, res_d;
  logic            accept;
  logic            valid_q, inv_q;
  logic [FLEN-1:0] res_q;

  assign ops[0] = opa_i;
  assign ops[1] = opb_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    nan_classify #(.FLEN(FLEN)) u_cls (
      .op_i      (ops[g]),
      .is_snan_o (snan_v[g]),
      .is_qnan_o (qnan_v[g])
    );
  end

  nan_arbiter #(.FLEN(FLEN)) u_arb (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .a_snan_i (snan_v[0]),
    .a_qnan_i (qnan_v[0]),
    .b_snan_i (snan_v[1]),
    .b_qnan_i (qnan_v[1]),
    .policy_i (policy_i),
    .pick_b_o (pick_b)
  );

  assign pick_op = pick_b ? opb_i : opa_i;

  nan_result_fmt #(.FLEN(FLEN)) u_fmt (
    .pick_i      (pick_op),
    .pick_snan_i (snan_v[pick_b]),
    .dflt_nan_i  (dflt_nan_i),
    .res_o       (res_d)
  );

  assign in_ready_o = ~valid_q | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      inv_q   <= 1'b0;
    end else if (accept) begin
      valid_q <= 1'b1;
      res_q   <= res_d;
      inv_q   <= |snan_v;
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign result_o    = res_q;
  assign invalid_o   = inv_q;

  a_r10_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o) && $stable(invalid_o));

  a_r9_never_snan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (&result_o[FLEN-2 -: EXP_W]) |-> result_o[MAN_W-1]);

  a_r2_flag_tracks_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> invalid_o == ($past(snan_v[0]) || $past(snan_v[1])));

  a_r3_default_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && dflt_nan_i |=> result_o == DFLT_NAN);

  a_r5_first_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !dflt_nan_i && policy_i == 2'd1 && qnan_v[0] |=> result_o == $past(opa_i));

  a_r1_empty_after_reset: assert property (@(posedge clk_i)
    !$past(rst_ni) |-> !out_valid_o);

endmodule

// File: tb/nan_pick_unit_tb.sv
module nan_pick_unit_tb;

  localparam int FLEN = 32;
  localparam logic [31:0] DNAN = 32'h7FC00000;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic            in_ready_o;
  logic [FLEN-1:0] opa_i = '0;
  logic [FLEN-1:0] opb_i = '0;
  logic [1:0]      policy_i = 2'd0;
  logic            dflt_nan_i = 1'b0;
  logic            out_valid_o;
  logic            out_ready_i = 1'b0;
  logic [FLEN-1:0] result_o;
  logic            invalid_o;

  always #2 clk_i = ~clk_i;

  nan_pick_unit #(.FLEN(FLEN)) u_dut (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .opa_i, .opb_i,
    .policy_i, .dflt_nan_i, .out_valid_o, .out_ready_i, .result_o, .invalid_o
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] va[$], vb[$];
  logic [1:0]  vp[$];
  logic        vd[$];
  string       vt[$];

  task automatic add(input logic [31:0] a, input logic [31:0] b,
                     input logic [1:0] p, input logic d, input string t);
    va.push_back(a); vb.push_back(b); vp.push_back(p); vd.push_back(d); vt.push_back(t);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // 0 non-NaN, 1 signaling, 2 quiet
  function automatic int kind(input logic [31:0] x);
    if (x[30:23] != 8'hFF || x[22:0] == 0) return 0;
    return x[22] ? 2 : 1;
  endfunction

  function automatic logic [32:0] ref_pick(input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] p, input logic d);
    int ka, kb;
    bit take_a;
    logic [31:0] r;
    ka = kind(a);
    kb = kind(b);
    if (p == 2'd1) take_a = (ka != 0);
    else if (p == 2'd2) begin
      if (ka != kb)               take_a = (ka > kb);
      else if (a[30:0] != b[30:0]) take_a = (a[30:0] > b[30:0]);
      else                         take_a = (a < b);
    end else take_a = (ka == 1) || (kb != 1 && ka == 2);
    r = take_a ? a : b;
    if (kind(r) == 1) r[22] = 1'b1;
    if (d) r = DNAN;
    return {(ka == 1 || kb == 1), r};
  endfunction

  function automatic logic [31:0] mk(input int k);
    logic [31:0] x;
    x[31] = 1'($urandom % 2);
    if (k == 1)      x[30:0] = {8'hFF, 1'b0, 22'($urandom % 4 + 1)};
    else if (k == 2) x[30:0] = {8'hFF, 1'b1, 22'($urandom % 4)};
    else             x[30:0] = {8'h3F, 23'($urandom)};
    return x;
  endfunction

  localparam logic [31:0] SA = 32'h7F800005;  // signaling, +
  localparam logic [31:0] SB = 32'hFF800009;  // signaling, -
  localparam logic [31:0] QA = 32'h7FC00003;
  localparam logic [31:0] QB = 32'hFFC00007;
  localparam logic [31:0] NUM = 32'h3F800000;

  logic        m_valid;
  logic [31:0] m_res;
  logic        m_inv;
  string       m_tag;

  initial begin
    int idx = 0;
    int cyc = 0;

    add(SA, QB, 2'd0, 1'b0, "R4");
    add(QA, SB, 2'd0, 1'b0, "R4");
    add(QA, QB, 2'd0, 1'b0, "R4");
    add(NUM, QB, 2'd0, 1'b0, "R4");
    add(NUM, SB, 2'd0, 1'b0, "R9");
    add(QA, SB, 2'd1, 1'b0, "R5");
    add(SA, QB, 2'd1, 1'b0, "R9");
    add(NUM, QB, 2'd1, 1'b0, "R5");
    add(SA, QB, 2'd2, 1'b0, "R6");
    add(QA, SB, 2'd2, 1'b0, "R6");
    add(SA, NUM, 2'd2, 1'b0, "R6");
    add(NUM, QB, 2'd2, 1'b0, "R6");
    add(QA, QB, 2'd2, 1'b0, "R7");
    add(32'h7F800001, 32'hFF800002, 2'd2, 1'b0, "R7");
    add(32'h7FC00004, 32'hFFC00004, 2'd2, 1'b0, "R8");
    add(32'hFFC00004, 32'h7FC00004, 2'd2, 1'b0, "R8");
    add(32'h7F800004, 32'h7F800004, 2'd2, 1'b0, "R8");
    add(QA, SB, 2'd3, 1'b0, "R11");
    add(SA, QB, 2'd3, 1'b0, "R11");
    add(SA, QB, 2'd2, 1'b1, "R3");
    add(QA, QB, 2'd0, 1'b1, "R3");
    add(NUM, SB, 2'd1, 1'b1, "R2");
    for (int i = 0; i < 300; i++) begin
      int ka = $urandom % 3;
      int kb = $urandom % 3;
      logic [1:0] p = 2'($urandom % 4);
      logic d = ($urandom % 8) == 0;
      string t;
      if (ka == 0 && kb == 0) ka = 2;
      t = d ? "R3" : (p == 2'd1) ? "R5" : (p == 2'd2) ? ((ka == kb) ? "R7" : "R6")
                                  : (p == 2'd3) ? "R11" : "R4";
      add(mk(ka), mk(kb), p, d, t);
    end

    m_valid = 1'b0; m_res = '0; m_inv = 1'b0; m_tag = "R1";
    repeat (3) @(negedge clk_i);
    #1 check(out_valid_o == 1'b0, "R1", "out_valid in reset", 64'(out_valid_o), 64'd0);
    rst_ni = 1'b1;

    while ((idx < va.size() || m_valid) && cyc < 20000) begin
      logic exp_rdy;
      logic [32:0] r;
      @(negedge clk_i);
      cyc++;
      check(out_valid_o == m_valid, (m_valid ? "R10" : "R1"), "out_valid",
            64'(out_valid_o), 64'(m_valid));
      if (m_valid && out_valid_o) begin
        check(result_o == m_res, m_tag, "result", 64'(result_o), 64'(m_res));
        check(invalid_o == m_inv, "R2", "invalid", 64'(invalid_o), 64'(m_inv));
      end
      out_ready_i = ($urandom % 4) != 0;
      if (idx < va.size()) begin
        in_valid_i = ($urandom % 5) != 0;
        opa_i = va[idx]; opb_i = vb[idx]; policy_i = vp[idx]; dflt_nan_i = vd[idx];
      end else in_valid_i = 1'b0;
      #1;
      exp_rdy = !m_valid || out_ready_i;
      check(in_ready_o == exp_rdy, "R10", "in_ready", 64'(in_ready_o), 64'(exp_rdy));
      if (in_valid_i && exp_rdy) begin
        r = ref_pick(va[idx], vb[idx], vp[idx], vd[idx]);
        m_valid = 1'b1; m_res = r[31:0]; m_inv = r[32]; m_tag = vt[idx];
        idx++;
      end else if (out_ready_i) m_valid = 1'b0;
    end

    if (cyc >= 20000) check(1'b0, "R10", "watchdog expired", 64'(cyc), 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule